// File: doc/BRIEF.md
# Accumulator ALU with carry

This block is the combinational arithmetic and logic stage of a single-accumulator processor. Each cycle the surrounding datapath presents the accumulator, one operand word fetched from memory, the current carry flag and a 4-bit operation select. The block returns the next accumulator value, the next carry value and a strobe that says whether the carry register should capture that value. It holds no state. The accumulator and flag registers, operand fetch and control-flow decoding all live outside it.

The select code is the opcode field of the instruction word, so a decoder needs no translation. The codes used are: 0 load, 2 add, 3 subtract, 4 OR, 5 AND, 6 XOR, 7 rotate right through carry, 8 half swap. Every other code (1 and 9 to 15) is treated as a non-data operation.

Add and subtract work on the accumulator and the operand, and do not read the incoming carry. Rotate and swap take only the memory operand. Load passes the operand through. Only add, subtract and rotate write the carry.

Top module: `acc_alu`

## Requirements
- R1: With select 2, the result is (accumulator + operand) mod 2^16, and the next carry is bit 16 of the 17-bit sum.
- R2: With select 3, the result is (accumulator − operand) mod 2^16, and the next carry is bit 16 of the 17-bit difference. That bit is 1 exactly when the operand is greater than the accumulator.
- R3: For selects 2 and 3, the result and the next carry are the same whether the incoming carry is 0 or 1.
- R4: With select 7, the result is the operand shifted right by one, with the incoming carry in bit 15. The next carry is operand bit 0.
- R5: With select 8, the result is the operand with bits 15:8 and 7:0 exchanged. The accumulator has no effect on this result.
- R6: Selects 4, 5 and 6 give the bitwise OR, AND and XOR of the operand and the accumulator.
- R7: With select 0, the result equals the operand.
- R8: With select 1 or any select from 9 to 15, the result equals the accumulator.
- R9: The carry-update strobe is 1 for selects 2, 3 and 7, and 0 for every other select.
- R10: Whenever the carry-update strobe is 0, the next-carry output equals the incoming carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 16 | Current accumulator value |
| mem_i | input | 16 | Operand word from memory |
| carry_i | input | 1 | Current carry flag |
| sel_i | input | 4 | Operation select (instruction opcode field) |
| result_o | output | 16 | Next accumulator value |
| carry_o | output | 1 | Next carry value |
| carry_we_o | output | 1 | Carry register update strobe |

## Verification
The bound checker tests every input combination the bench applies, as the combinational inputs settle. It checks:
- add and subtract against their inverse relations;
- the rotate bit placement;
- the bit-count conservation of the swap;
- the covering and masking properties of OR, AND and XOR;
- the accumulator pass-through for non-data codes;
- the rule that the strobe comes only from the three carry-writing operations, and that the incoming carry passes through when the strobe is low.

Two properties are not visible from a single input combination: that the incoming carry has no effect on add and subtract, and that the accumulator has no effect on swap. The bench shows these by applying paired vectors that differ only in the ignored input. The bench also hits directed wrap and borrow corners.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
   localparam int unsigned SEL_W = 4;

   localparam logic [SEL_W-1:0] SEL_LOAD = 4'h0;
   localparam logic [SEL_W-1:0] SEL_ADD  = 4'h2;
   localparam logic [SEL_W-1:0] SEL_SUB  = 4'h3;
   localparam logic [SEL_W-1:0] SEL_OR   = 4'h4;
   localparam logic [SEL_W-1:0] SEL_AND  = 4'h5;
   localparam logic [SEL_W-1:0] SEL_XOR  = 4'h6;
   localparam logic [SEL_W-1:0] SEL_ROR  = 4'h7;
   localparam logic [SEL_W-1:0] SEL_SWAP = 4'h8;

   function automatic logic writes_carry(input logic [SEL_W-1:0] s);
      return (s == SEL_ADD) || (s == SEL_SUB) || (s == SEL_ROR);
   endfunction
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
   parameter int unsigned DATA_W       = 16,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              is_sub_i,
   output logic [DATA_W-1:0] res_o,
   output logic              c17_o
);
   localparam int unsigned EXT_W = DATA_W + 1;

   generate
      if (SHARED_ADDER) begin : g_shared
         // One adder: subtraction adds the inverted operand plus one.
         // The carry out of that sum is the inverse of the borrow.
         logic [DATA_W-1:0] b_eff;
         logic [EXT_W-1:0]  wide;
         assign b_eff = is_sub_i ? ~b_i : b_i;
         assign wide  = {1'b0, a_i} + {1'b0, b_eff} + EXT_W'(is_sub_i);
         assign res_o = wide[DATA_W-1:0];
         assign c17_o = wide[DATA_W] ^ is_sub_i;
      end else begin : g_split
         logic [EXT_W-1:0] sum_w;
         logic [EXT_W-1:0] dif_w;
         assign sum_w = {1'b0, a_i} + {1'b0, b_i};
         assign dif_w = {1'b0, a_i} - {1'b0, b_i};
         assign res_o = is_sub_i ? dif_w[DATA_W-1:0] : sum_w[DATA_W-1:0];
         assign c17_o = is_sub_i ? dif_w[DATA_W] : sum_w[DATA_W];
      end
   endgenerate
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
   parameter int unsigned DATA_W = 16
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [1:0]        fn_i,
   output logic [DATA_W-1:0] res_o
);
   // fn_i: 0 OR, 1 AND, 2 XOR, 3 operand pass-through
   always_comb begin
      unique case (fn_i)
         2'd0:    res_o = a_i | b_i;
         2'd1:    res_o = a_i & b_i;
         2'd2:    res_o = a_i ^ b_i;
         default: res_o = b_i;
      endcase
   end
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift #(
   parameter int unsigned DATA_W = 16
) (
   input  logic [DATA_W-1:0] b_i,
   input  logic              cin_i,
   output logic [DATA_W-1:0] ror_o,
   output logic              ror_c_o,
   output logic [DATA_W-1:0] swap_o
);
   localparam int unsigned HALF = DATA_W / 2;

   assign ror_o   = {cin_i, b_i[DATA_W-1:1]};
   assign ror_c_o = b_i[0];

   for (genvar i = 0; i < HALF; i++) begin : g_swap
      assign swap_o[i]        = b_i[i + HALF];
      assign swap_o[i + HALF] = b_i[i];
   end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int unsigned DATA_W       = 16,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] mem_i,
   input  logic              carry_i,
   input  logic [SEL_W-1:0]  sel_i,
   output logic [DATA_W-1:0] result_o,
   output logic              carry_o,
   output logic              carry_we_o
);
   generate
      if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("acc_alu: DATA_W must be even and at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] arith_res;
   logic              arith_c;
   logic [DATA_W-1:0] logic_res;
   logic [DATA_W-1:0] ror_res;
   logic              ror_c;
   logic [DATA_W-1:0] swap_res;
   logic [1:0]        logic_fn;

   acc_alu_arith #(.DATA_W(DATA_W), .SHARED_ADDER(SHARED_ADDER)) u_arith (
      .a_i      (acc_i),
      .b_i      (mem_i),
      .is_sub_i (sel_i == SEL_SUB),
      .res_o    (arith_res),
      .c17_o    (arith_c)
   );

   always_comb begin
      unique case (sel_i)
         SEL_OR:  logic_fn = 2'd0;
         SEL_AND: logic_fn = 2'd1;
         SEL_XOR: logic_fn = 2'd2;
         default: logic_fn = 2'd3;
      endcase
   end

   acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
      .a_i   (acc_i),
      .b_i   (mem_i),
      .fn_i  (logic_fn),
      .res_o (logic_res)
   );

   acc_alu_shift #(.DATA_W(DATA_W)) u_shift (
      .b_i     (mem_i),
      .cin_i   (carry_i),
      .ror_o   (ror_res),
      .ror_c_o (ror_c),
      .swap_o  (swap_res)
   );

   always_comb begin
      result_o   = acc_i;
      carry_o    = carry_i;
      carry_we_o = 1'b0;
      unique case (sel_i)
         SEL_ADD, SEL_SUB: begin
            result_o   = arith_res;
            carry_o    = arith_c;
            carry_we_o = 1'b1;
         end
         SEL_ROR: begin
            result_o   = ror_res;
            carry_o    = ror_c;
            carry_we_o = 1'b1;
         end
         SEL_SWAP: result_o = swap_res;
         SEL_LOAD, SEL_OR, SEL_AND, SEL_XOR: result_o = logic_res;
         default: ;
      endcase
   end
endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker
   import acc_alu_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input logic [DATA_W-1:0] acc_i,
   input logic [DATA_W-1:0] mem_i,
   input logic              carry_i,
   input logic [SEL_W-1:0]  sel_i,
   input logic [DATA_W-1:0] result_o,
   input logic              carry_o,
   input logic              carry_we_o
);
   localparam int unsigned HALF = DATA_W / 2;

   logic known;
   assign known = !$isunknown({acc_i, mem_i, carry_i, sel_i});

   always_comb begin
      if (known) begin
         if (sel_i == SEL_ADD) begin
            assert_add_inverse_R1: assert (({carry_o, result_o} - {1'b0, mem_i}) == {1'b0, acc_i})
               else $error("add inverse relation broken");
         end
         if (sel_i == SEL_SUB) begin
            assert_sub_inverse_R2: assert (DATA_W'(result_o + mem_i) == acc_i && carry_o == (acc_i < mem_i))
               else $error("sub inverse relation broken");
         end
         if (sel_i == SEL_ROR) begin
            assert_ror_bits_R4: assert (result_o[DATA_W-1] == carry_i && carry_o == mem_i[0]
                                        && result_o[DATA_W-2:0] == mem_i[DATA_W-1:1])
               else $error("rotate placement broken");
         end
         if (sel_i == SEL_SWAP) begin
            assert_swap_halves_R5: assert ($countones(result_o) == $countones(mem_i)
                                           && result_o[HALF-1:0] == mem_i[DATA_W-1:HALF])
               else $error("swap broken");
         end
         if (sel_i == SEL_OR) begin
            assert_or_cover_R6: assert ((result_o & mem_i) == mem_i && (result_o & acc_i) == acc_i
                                        && (result_o & ~(mem_i | acc_i)) == '0)
               else $error("or broken");
         end
         if (sel_i == SEL_AND) begin
            assert_and_mask_R6: assert ((result_o & ~mem_i) == '0 && (result_o & ~acc_i) == '0
                                        && (result_o | ~(mem_i & acc_i)) == '1)
               else $error("and broken");
         end
         if (sel_i == SEL_XOR) begin
            assert_xor_undo_R6: assert ((result_o ^ mem_i) == acc_i)
               else $error("xor broken");
         end
         if (sel_i == SEL_LOAD) begin
            assert_load_pass_R7: assert (result_o == mem_i)
               else $error("load broken");
         end
         if (sel_i == 4'h1 || sel_i > SEL_SWAP) begin
            assert_nondata_hold_R8: assert (result_o == acc_i && !carry_we_o)
               else $error("non-data code changed accumulator");
         end
         if (carry_we_o) begin
            assert_we_source_R9: assert (sel_i == SEL_ADD || sel_i == SEL_SUB || sel_i == SEL_ROR)
               else $error("strobe from wrong operation");
         end
         if (!carry_we_o) begin
            assert_carry_hold_R10: assert (carry_o == carry_i)
               else $error("carry changed without strobe");
         end
      end
   end
endmodule

bind acc_alu acc_alu_checker #(.DATA_W(DATA_W)) u_chk (
   .acc_i      (acc_i),
   .mem_i      (mem_i),
   .carry_i    (carry_i),
   .sel_i      (sel_i),
   .result_o   (result_o),
   .carry_o    (carry_o),
   .carry_we_o (carry_we_o)
);

// File: tb/acc_alu_test.sv
module acc_alu_test;
   logic        clk = 1'b0;
   logic [15:0] acc;
   logic [15:0] mem;
   logic        cin;
   logic [3:0]  sel;
   logic [15:0] res;
   logic        cout;
   logic        cwe;

   int unsigned n_vec  = 0;
   int unsigned n_fail = 0;
   bit          done   = 1'b0;

   always #4 clk = ~clk;

   acc_alu uut (
      .acc_i      (acc),
      .mem_i      (mem),
      .carry_i    (cin),
      .sel_i      (sel),
      .result_o   (res),
      .carry_o    (cout),
      .carry_we_o (cwe)
   );

   // Reference model written from the requirements: {we, carry, result}
   function automatic logic [17:0] model(input logic [3:0] s, input logic [15:0] a,
                                         input logic [15:0] m, input logic c);
      logic [16:0] w;
      case (s)
         4'h0: return {1'b0, c, m};
         4'h2: begin w = {1'b0, a} + {1'b0, m}; return {1'b1, w}; end
         4'h3: begin w = {1'b0, a} - {1'b0, m}; return {1'b1, w}; end
         4'h4: return {1'b0, c, a | m};
         4'h5: return {1'b0, c, a & m};
         4'h6: return {1'b0, c, a ^ m};
         4'h7: return {1'b1, m[0], c, m[15:1]};
         4'h8: return {1'b0, c, m[7:0], m[15:8]};
         default: return {1'b0, c, a};
      endcase
   endfunction

   function automatic string tag_of(input logic [3:0] s);
      case (s)
         4'h0: return "R7";
         4'h2: return "R1";
         4'h3: return "R2";
         4'h4, 4'h5, 4'h6: return "R6";
         4'h7: return "R4";
         4'h8: return "R5";
         default: return "R8";
      endcase
   endfunction

   task automatic apply(input logic [3:0] s, input logic [15:0] a,
                        input logic [15:0] m, input logic c);
      logic [17:0] exp;
      @(negedge clk);
      sel = s; acc = a; mem = m; cin = c;
      #1;
      exp = model(s, a, m, c);
      n_vec++;
      if (res !== exp[15:0] || cout !== exp[16] || cwe !== exp[17]) begin
         n_fail++;
         $display("FAIL %s/R9/R10 sel=%h acc=%h mem=%h cin=%b: got we=%b c=%b r=%h exp we=%b c=%b r=%h",
                  tag_of(s), s, a, m, c, cwe, cout, res, exp[17], exp[16], exp[15:0]);
      end
   endtask

   // Paired vectors differing only in an input that must have no effect
   task automatic pair(input string tag, input logic [3:0] s, input logic [15:0] a,
                       input logic [15:0] m, input logic c, input logic [15:0] a2, input logic c2);
      logic [16:0] first;
      @(negedge clk);
      sel = s; acc = a; mem = m; cin = c;
      #1;
      first = {cout, res};
      @(negedge clk);
      acc = a2; cin = c2;
      #1;
      n_vec++;
      if ({cout, res} !== first) begin
         n_fail++;
         $display("FAIL %s sel=%h: got %h expected %h", tag, s, {cout, res}, first);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = 32'h5eed_1234;
      void'($urandom(seed));
      sel = 4'h0; acc = '0; mem = '0; cin = 1'b0;
      repeat (2) @(posedge clk);

      // R1 wrap and carry-out
      apply(4'h2, 16'hFFFF, 16'h0001, 1'b0);
      apply(4'h2, 16'h8000, 16'h8000, 1'b1);
      apply(4'h2, 16'h1234, 16'h0000, 1'b1);
      // R2 borrow and zero
      apply(4'h3, 16'h0000, 16'h0001, 1'b0);
      apply(4'h3, 16'h0005, 16'h0005, 1'b1);
      apply(4'h3, 16'hFFFF, 16'h0001, 1'b1);
      // R3 incoming carry ignored by add and subtract
      pair("R3", 4'h2, 16'h7FFF, 16'h0001, 1'b0, 16'h7FFF, 1'b1);
      pair("R3", 4'h3, 16'h0001, 16'h0002, 1'b1, 16'h0001, 1'b0);
      // R4 rotate through carry
      apply(4'h7, 16'h0000, 16'h0001, 1'b1);
      apply(4'h7, 16'hFFFF, 16'hFFFE, 1'b0);
      // R5 swap; accumulator has no effect
      apply(4'h8, 16'hAAAA, 16'h1234, 1'b0);
      pair("R5", 4'h8, 16'h0000, 16'hBEEF, 1'b1, 16'hFFFF, 1'b1);
      // R6 logic, R7 load
      apply(4'h4, 16'hF0F0, 16'h0FF0, 1'b1);
      apply(4'h5, 16'hF0F0, 16'h0FF0, 1'b0);
      apply(4'h6, 16'hFFFF, 16'h00FF, 1'b1);
      apply(4'h0, 16'hDEAD, 16'h5A5A, 1'b1);
      // R8 non-data codes, R9 strobe low, R10 carry held
      apply(4'h1, 16'hCAFE, 16'h1111, 1'b1);
      for (int k = 9; k < 16; k++) apply(4'(k), 16'h0F0F, 16'hFFFF, 1'(k & 1));

      // Constrained random: every code, biased operand extremes
      for (int i = 0; i < 3000; i++) begin
         logic [15:0] a;
         logic [15:0] m;
         a = 16'($urandom());
         m = 16'($urandom());
         if ($urandom_range(0, 7) == 0) a = 16'hFFFF;
         if ($urandom_range(0, 7) == 0) m = 16'h0000;
         apply(4'($urandom_range(0, 15)), a, m, 1'($urandom()));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule